// File: doc/BRIEF.md
# Flash Memory Command State Machine

This block is a clock-synchronous model of the command interface of a byte-wide parallel flash memory. A host drives active-low chip-enable, write-enable and output-enable strobes, an address bus, a data input byte and a program-voltage-enable level. The block samples the strobes on the system clock and finds the edges of each write cycle. It latches the address when write-enable falls and takes the command byte when write-enable rises. From these bytes it selects one of five modes: array read, signature read, erase setup, erasing and erase verify.

The storage is a small register array with a parameterized depth. After reset it holds a computed pattern. A bulk erase is armed by a first 0x20 write and started by a second 0x20 write that follows it directly. While erasing, a stop timer clears every byte to 0xFF at the end of each timer period. The host ends the erase by writing the verify command 0xA0. That write also captures the address to check, and later read cycles return the byte stored there.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After reset the mode is array read, `busy` is 0, and with all strobes high `dout_valid` is 0. Byte i of the array holds (i*29 + 66) mod 256.
- R2: A committed write of 0x00 selects array read. A read cycle then returns the stored byte at the address on `addr`.
- R3: While `vpp_en` is 0, command writes are ignored and the mode returns to array read one clock later.
- R4: A committed write of 0x90 selects signature read. A read at address 0 returns 0x31, at address 1 returns 0xBD, and at any other address returns 0x00.
- R5: A write of 0x20 only arms erase. A second 0x20 write that follows directly starts erasing, and `busy` is 1 from the clock edge that samples its rising write-enable.
- R6: If the write after a single 0x20 is anything other than 0x20, the erase is cancelled, the mode becomes array read, and that byte is not run as a command.
- R7: While erasing, every ERASE_CYCLES clocks the whole array is set to 0xFF. If erasing stops before the first period ends, the array is unchanged.
- R8: While erasing, only a 0xA0 write ends the erase: `busy` drops and the mode becomes erase verify. The verify address is the `addr` value sampled when write-enable fell, and verify reads return that byte whatever is on `addr`.
- R9: `dout_valid` is 1 only when `ce_n` and `oe_n` are 0 and `we_n` is 1. When `dout_valid` is 0, `dout` is 0x00.
- R10: In array-read and signature modes, a byte other than 0x00, 0x90 and 0x20 is ignored and leaves the mode unchanged. This includes 0xA0, which has an effect only while erasing or in erase verify.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the strobes are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low; the address is latched on its fall and the command taken on its rise |
| oe_n | input | 1 | Output enable, active low |
| vpp_en | input | 1 | Program-voltage enable; command writes are accepted only while it is high |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Command byte from the host |
| dout | output | 8 | Read data |
| dout_valid | output | 1 | High while a read cycle drives `dout` |
| busy | output | 1 | High while erasing |

## Verification
The assertions check the mode rules on every cycle: the forced return to array read while `vpp_en` is low, the cancel after a lone setup byte, the start of erasing on a second setup byte, that `busy` holds until a verify command, that unknown bytes leave the mode alone, and that no output is driven during a write. Only the bench's scenarios can show the data side: the signature codes, the stored pattern, the latched verify address against a changed bus address, and the bulk fill to 0xFF after a full timer period compared with an early stop that leaves the data unchanged.

// File: rtl/flash_cmd_pkg.sv
// Package: shared mode type and command codes for the flash command block.
// Assumes: command bytes are 8 bits wide.
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        MODE_READ    = 3'd0,
        MODE_SIG     = 3'd1,
        MODE_ESETUP  = 3'd2,
        MODE_ERASE   = 3'd3,
        MODE_EVERIFY = 3'd4
    } flash_mode_e;

    localparam logic [7:0] CMD_READ   = 8'h00;
    localparam logic [7:0] CMD_SIG    = 8'h90;
    localparam logic [7:0] CMD_ERASE  = 8'h20;
    localparam logic [7:0] CMD_VERIFY = 8'hA0;

    localparam logic [7:0] SIG_MAKER  = 8'h31;
    localparam logic [7:0] SIG_DEVICE = 8'hBD;

    // Power-up content of byte idx in the array.
    function automatic logic [7:0] init_byte(input int idx);
        return 8'((idx * 29 + 66) % 256);
    endfunction

endpackage

// File: rtl/flash_strobe_sync.sv
// Module: flash_strobe_sync
// Finds the start and end of each host write cycle from the write-enable
// strobe sampled on the system clock. It latches the address at the start.
// Assumes: the strobes are stable around clock edges, and chip-enable is low
// through the whole write cycle.
module flash_strobe_sync #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              wr_start,
    output logic              wr_commit,
    output logic [ADDR_W-1:0] addr_lat
);

    logic we_n_q;

    // Edge events: a fall opens a write cycle, a rise closes it.
    assign wr_start  = we_n_q & ~we_n & ~ce_n;
    assign wr_commit = ~we_n_q & we_n & ~ce_n;

    // Keep the previous write-enable level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) we_n_q <= 1'b1;
        else        we_n_q <= we_n;
    end

    // Capture the address on the falling write-enable edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        addr_lat <= '0;
        else if (wr_start) addr_lat <= addr;
    end

endmodule

// File: rtl/flash_erase_timer.sv
// Module: flash_erase_timer
// Stop timer for bulk erase. While run is high it counts clock cycles and
// raises erase_pulse for one cycle at the end of each period.
// Assumes: PERIOD >= 2.
module flash_erase_timer #(
    parameter int PERIOD = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic erase_pulse
);

    localparam int CNT_W = $clog2(PERIOD);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt;

    assign erase_pulse = run && (cnt == LAST);

    // Count while running, wrap at the end of each period, clear when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/flash_array.sv
// Module: flash_array
// Byte register array with two combinational read ports and a bulk clear
// to 0xFF. Reset loads a computed pattern.
// Assumes: DEPTH is a power of two that matches ADDR_W.
module flash_array
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase_all,
    input  logic [ADDR_W-1:0] rd_addr_bus,
    input  logic [ADDR_W-1:0] rd_addr_ver,
    output logic [7:0]        rd_data_bus,
    output logic [7:0]        rd_data_ver
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    // One register per byte: load the pattern on reset, clear on erase.
    for (genvar g = 0; g < DEPTH; g++) begin : g_byte
        always_ff @(posedge clk) begin
            if (!rst_n)         mem[g] <= init_byte(g);
            else if (erase_all) mem[g] <= 8'hFF;
        end
    end

    assign rd_data_bus = mem[rd_addr_bus];
    assign rd_data_ver = mem[rd_addr_ver];

endmodule

// File: rtl/flash_cmd_decode.sv
// Module: flash_cmd_decode
// Command register and mode state machine. It acts on each committed write
// while the program voltage is enabled, and captures the verify address.
// Assumes: din holds the command byte in the cycle wr_commit is high.
module flash_cmd_decode
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vpp_en,
    input  logic              wr_commit,
    input  logic [7:0]        din,
    input  logic [ADDR_W-1:0] addr_lat,
    output flash_mode_e       mode,
    output logic [ADDR_W-1:0] ver_addr
);

    flash_mode_e mode_nxt;

    // Next-mode decode for one accepted command byte.
    always_comb begin
        mode_nxt = mode;
        if (!vpp_en) begin
            mode_nxt = MODE_READ;
        end else if (wr_commit) begin
            unique case (mode)
                MODE_ESETUP:
                    mode_nxt = (din == CMD_ERASE) ? MODE_ERASE : MODE_READ;
                MODE_ERASE:
                    if (din == CMD_VERIFY) mode_nxt = MODE_EVERIFY;
                default: begin
                    if (din == CMD_READ)       mode_nxt = MODE_READ;
                    else if (din == CMD_SIG)   mode_nxt = MODE_SIG;
                    else if (din == CMD_ERASE) mode_nxt = MODE_ESETUP;
                    else if (din == CMD_VERIFY && mode == MODE_EVERIFY)
                        mode_nxt = MODE_EVERIFY;
                end
            endcase
        end
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) mode <= MODE_READ;
        else        mode <= mode_nxt;
    end

    // Verify address: taken from the write-start latch when a verify commits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ver_addr <= '0;
        else if (vpp_en && wr_commit && din == CMD_VERIFY &&
                 (mode == MODE_ERASE || mode == MODE_EVERIFY))
            ver_addr <= addr_lat;
    end

endmodule

// File: rtl/flash_read_path.sv
// Module: flash_read_path
// Chooses the read data by mode and gates it with the read strobes.
// Assumes: the array read ports are combinational.
module flash_read_path
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  flash_mode_e       mode,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        arr_bus,
    input  logic [7:0]        arr_ver,
    output logic [7:0]        dout,
    output logic              dout_valid
);

    logic [7:0] sel;

    // Source select: signature codes, verify byte, or array at the bus address.
    always_comb begin
        unique case (mode)
            MODE_SIG: begin
                if (addr == ADDR_W'(0))      sel = SIG_MAKER;
                else if (addr == ADDR_W'(1)) sel = SIG_DEVICE;
                else                         sel = 8'h00;
            end
            MODE_EVERIFY: sel = arr_ver;
            default:      sel = arr_bus;
        endcase
    end

    assign dout_valid = ~ce_n & ~oe_n & we_n;
    assign dout       = dout_valid ? sel : 8'h00;

endmodule

// File: rtl/flash_cmd_fsm.sv
// Module: flash_cmd_fsm (top)
// Command interface of a byte-wide flash: strobe edge detection, command
// decode, erase stop timer, register array and read path.
// Assumes: the host drives the strobes in step with clk and holds each level
// for at least one clock.
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W       = 4,
    parameter int ERASE_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              vpp_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_valid,
    output logic              busy
);

    logic              wr_start;
    logic              wr_commit;
    logic [ADDR_W-1:0] addr_lat;
    logic [ADDR_W-1:0] ver_addr;
    logic              erase_pulse;
    logic [7:0]        arr_bus;
    logic [7:0]        arr_ver;
    flash_mode_e       mode;

    flash_strobe_sync #(.ADDR_W(ADDR_W)) u_sync (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr),
        .wr_start(wr_start), .wr_commit(wr_commit), .addr_lat(addr_lat)
    );

    flash_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .vpp_en(vpp_en), .wr_commit(wr_commit),
        .din(din), .addr_lat(addr_lat), .mode(mode), .ver_addr(ver_addr)
    );

    assign busy = (mode == MODE_ERASE);

    flash_erase_timer #(.PERIOD(ERASE_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run(busy), .erase_pulse(erase_pulse)
    );

    flash_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .erase_all(erase_pulse),
        .rd_addr_bus(addr), .rd_addr_ver(ver_addr),
        .rd_data_bus(arr_bus), .rd_data_ver(arr_ver)
    );

    flash_read_path #(.ADDR_W(ADDR_W)) u_rd (
        .mode(mode), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr),
        .arr_bus(arr_bus), .arr_ver(arr_ver),
        .dout(dout), .dout_valid(dout_valid)
    );

endmodule

// File: rtl/flash_cmd_checker.sv
// Module: flash_cmd_checker
// Temporal checks on the command state machine. It is bound into flash_cmd_fsm.
module flash_cmd_checker
    import flash_cmd_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        we_n,
    input logic        vpp_en,
    input logic        wr_commit,
    input logic [7:0]  din,
    input flash_mode_e mode,
    input logic        busy,
    input logic        dout_valid
);

    assert_vpp_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !vpp_en |=> mode == MODE_READ);

    assert_erase_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (vpp_en && wr_commit && mode == MODE_ESETUP && din == CMD_ERASE) |=> busy);

    assert_setup_cancel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vpp_en && wr_commit && mode == MODE_ESETUP && din != CMD_ERASE)
        |=> mode == MODE_READ);

    assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && vpp_en && !(wr_commit && din == CMD_VERIFY)) |=> busy);

    assert_unknown_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (vpp_en && wr_commit && (mode == MODE_READ || mode == MODE_SIG) &&
         din != CMD_READ && din != CMD_SIG && din != CMD_ERASE) |=> $stable(mode));

    assert_no_drive_in_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !dout_valid);

endmodule

bind flash_cmd_fsm flash_cmd_checker u_chk (
    .clk(clk), .rst_n(rst_n), .we_n(we_n), .vpp_en(vpp_en),
    .wr_commit(wr_commit), .din(din), .mode(mode), .busy(busy),
    .dout_valid(dout_valid)
);

// File: tb/sim_flash_cmd_fsm.sv
// Directed bench for flash_cmd_fsm: one task per scenario.
module sim_flash_cmd_fsm;

    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;
    localparam int ECYC  = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, vpp_en = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = 8'h00;
    logic [7:0]    dout;
    logic          dout_valid, busy;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    flash_cmd_fsm #(.ADDR_W(AW), .ERASE_CYCLES(ECYC)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .vpp_en(vpp_en), .addr(addr), .din(din),
        .dout(dout), .dout_valid(dout_valid), .busy(busy)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 29 + 66) % 256);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Write cycle: the address at the write-enable fall is a_fall and at the rise is a_rise.
    task automatic wr(input logic [7:0] d, input logic [AW-1:0] a_fall, input logic [AW-1:0] a_rise);
        @(negedge clk); ce_n = 1'b0; addr = a_fall; din = d; we_n = 1'b0;
        @(negedge clk); addr = a_rise; we_n = 1'b1;
        @(negedge clk); ce_n = 1'b1;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; addr = a;
        #1 d = dout;
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        #1 check("R1 busy after reset", busy, 0);
        check("R1 dout_valid idle", dout_valid, 0);
        rd(4'd5, d);
        check("R1 pattern byte 5", d, pat(5));
    endtask

    task automatic t_strobes;
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b0;
        #1 check("R9 valid low with ce_n high", dout_valid, 0);
        check("R9 dout zero when invalid", dout, 0);
        ce_n = 1'b0; we_n = 1'b0;
        #1 check("R9 valid low with we_n low", dout_valid, 0);
        we_n = 1'b1;
        #1 check("R9 valid high on read", dout_valid, 1);
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic t_array_read;
        logic [7:0] d;
        wr(8'h00, '0, '0);
        for (int i = 0; i < DEPTH; i += 5) begin
            rd(AW'(i), d);
            check("R2 array read", d, pat(i));
        end
    endtask

    task automatic t_signature;
        logic [7:0] d;
        wr(8'h90, '0, '0);
        rd(4'd0, d); check("R4 maker code", d, 8'h31);
        rd(4'd1, d); check("R4 device code", d, 8'hBD);
        rd(4'd6, d); check("R4 other address", d, 8'h00);
        wr(8'h55, '0, '0);
        rd(4'd0, d); check("R10 unknown keeps signature", d, 8'h31);
        wr(8'h00, '0, '0);
        wr(8'hA0, 4'd7, 4'd7);
        rd(4'd2, d); check("R10 A0 ignored in read mode", d, pat(2));
    endtask

    task automatic t_vpp_low;
        logic [7:0] d;
        vpp_en = 1'b0;
        wr(8'h90, '0, '0);
        rd(4'd0, d); check("R3 write ignored with vpp low", d, pat(0));
        wr(8'h20, '0, '0);
        wr(8'h20, '0, '0);
        #1 check("R3 no erase with vpp low", busy, 0);
        vpp_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_cancel;
        logic [7:0] d;
        wr(8'h20, '0, '0);
        #1 check("R5 single setup not busy", busy, 0);
        wr(8'h90, '0, '0);
        #1 check("R6 cancel not busy", busy, 0);
        rd(4'd0, d); check("R6 cancel returns array read", d, pat(0));
    endtask

    task automatic t_early_verify;
        logic [7:0] d;
        wr(8'h20, '0, '0);
        wr(8'h20, '0, '0);
        #1 check("R5 busy after second setup", busy, 1);
        wr(8'h33, '0, '0);
        #1 check("R8 non-verify keeps busy", busy, 1);
        wr(8'hA0, 4'd4, 4'd9);
        #1 check("R8 verify ends erase", busy, 0);
        rd(4'd2, d); check("R8 verify byte at fall address", d, pat(4));
        check("R7 early stop keeps data", d, pat(4));
        wr(8'h00, '0, '0);
    endtask

    task automatic t_full_erase;
        logic [7:0] d;
        wr(8'h20, '0, '0);
        wr(8'h20, '0, '0);
        repeat (ECYC + 5) @(negedge clk);
        #1 check("R5 still busy during erase", busy, 1);
        wr(8'hA0, 4'd3, 4'd3);
        rd(4'd3, d); check("R7 verify byte erased", d, 8'hFF);
        wr(8'h00, '0, '0);
        for (int i = 0; i < DEPTH; i++) begin
            rd(AW'(i), d);
            if (i % 4 == 0 || i == DEPTH - 1) check("R7 array erased", d, 8'hFF);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_strobes();
        t_array_read();
        t_signature();
        t_vpp_low();
        t_cancel();
        t_early_verify();
        t_full_erase();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule